// File: doc/BRIEF.md
# Stereo display frame sequencer

This block produces the timing of one display frame for a two-eye display that is scanned column by column. A frame lasts 20 ms. It is cut into an idle window, a left-eye scan, a short idle, a frame-clock fall, another idle, a right-eye scan and a closing idle. During each scan the block steps a column index through every column. The length of each column alternates between a base period and one clock more, following a fixed 12-column pattern. Over a full scan the pattern adds up to exactly 5 ms.

Downstream logic uses the column strobe and index to fetch pixels. It uses the column-table address to look up per-column data. Two event pulses go to an interrupt controller: one marks the start of the frame and one marks the end of each eye. A buffer-select input chooses which of two frame buffers each eye shows. The block raises the busy flag of the chosen buffer for as long as that eye is scanned.

All timing is set by parameters: clocks per millisecond (default 20000), columns per eye (default 384) and the base column period (default 260).

Top module: `stereo_frame_seq`

## Requirements
- R1: While reset is high, every flag, pulse and the column strobe are low. The first clock edge after reset is released raises the frame clock and fires the frame-start pulse at once.
- R2: The frame-start pulse lasts one cycle and coincides with the frame-clock rise. The left busy flag rises exactly 3 ms later.
- R3: Each scan starts with a strobe for column 0 in the cycle its busy flag rises. Column k+1 starts exactly P(k) clocks after column k, where P(k) = base + bit (k mod 12) of 12'hA94. Each strobe lasts one cycle and carries column index k.
- R4: The left busy flag falls, together with a one-cycle left-end pulse, P(last) clocks after the last left column starts. The frame clock falls 2 ms after that.
- R5: The right busy flag rises 3 ms after the frame clock falls. After its last column the right busy flag falls with a one-cycle right-end pulse. The next frame-start follows 2 ms later.
- R6: The left table address for column k equals (18'h3DC00 OR leftStart·2) − 2·floor(k/4). The start byte is sampled when the left busy flag rises.
- R7: Throughout the right scan the table address stays at 18'h3DE00 OR rightStart·2. The start byte is sampled when the right busy flag rises.
- R8: When an eye's busy flag rises, bufSel=0 selects that eye's buffer-0 flag and bufSel=1 selects its buffer-1 flag. The chosen flag stays the one that is high until that eye ends, even if bufSel changes in between.
- R9: At most one busy flag is high at a time. Left busy flags are high only while the frame clock is high, and right busy flags only while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bufSel | input | 1 | Frame buffer chosen for the next eye scan |
| leftStart | input | 8 | Start byte of the left column table |
| rightStart | input | 8 | Start byte of the right column table |
| frameClk | output | 1 | Frame clock flag |
| busyLeft0 | output | 1 | Left eye scanning buffer 0 |
| busyLeft1 | output | 1 | Left eye scanning buffer 1 |
| busyRight0 | output | 1 | Right eye scanning buffer 0 |
| busyRight1 | output | 1 | Right eye scanning buffer 1 |
| colStrobe | output | 1 | One-cycle pulse at each column start |
| colIdx | output | $clog2(NUM_COLS) | Index of the current column |
| tblAddr | output | 18 | Column-table address of the current column |
| evFrameStart | output | 1 | Frame-start event pulse |
| evLeftEnd | output | 1 | Left-eye end event pulse |
| evRightEnd | output | 1 | Right-eye end event pulse |

## Verification
The hardest case to reach from the ports is bufSel changing while a scan is in progress. The flag already raised must stay up and must be the one that falls, and the other eye must then pick up the new value. The bench toggles bufSel in the middle of a left scan and then checks the two eyes against two different buffers. To reach several frames quickly, the bench shrinks the millisecond to 20 clocks and the scan to 24 columns. It keeps the real 260-clock base period and the full 12-column pattern, so every pattern phase and the every-fourth-column address decrement are still exercised twice per eye.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  // Extra-clock pattern over 12 consecutive columns (bit n for column mod 12 == n)
  localparam logic [11:0] COL_PATTERN = 12'hA94;
  localparam int          ADDR_W      = 18;
  localparam logic [ADDR_W-1:0] LEFT_BASE  = 18'h3DC00;
  localparam logic [ADDR_W-1:0] RIGHT_BASE = 18'h3DE00;

  typedef struct packed {
    logic riseFclk;
    logic fallFclk;
    logic beginLeft;
    logic beginRight;
    logic nextCol;
    logic endLeft;
    logic endRight;
  } sfsStrobes_t;

endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int CLKS_PER_MS = 20000,
  parameter int COL_BASE    = 260
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lastCol,
  input  logic        nextBit,
  output sfsStrobes_t strb
);

  localparam int IDLE_LONG  = 3 * CLKS_PER_MS;
  localparam int IDLE_SHORT = 2 * CLKS_PER_MS;
  localparam int LONGEST    = (IDLE_LONG > COL_BASE + 1) ? IDLE_LONG : COL_BASE + 1;
  localparam int WAIT_W     = $clog2(LONGEST + 1);

  typedef enum logic [2:0] {
    ST_RISE, ST_LBEGIN, ST_LSCAN, ST_FALL, ST_RBEGIN, ST_RSCAN
  } sfsState_t;

  sfsState_t           state, stateNext;
  logic [WAIT_W-1:0]   waitCnt, waitNext;
  logic                expired;

  assign expired = (waitCnt == '0);

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (expired) begin
      unique case (state)
        ST_RISE:   begin strb.riseFclk   = 1'b1; stateNext = ST_LBEGIN; end
        ST_LBEGIN: begin strb.beginLeft  = 1'b1; stateNext = ST_LSCAN;  end
        ST_LSCAN:  begin
          if (lastCol) begin strb.endLeft = 1'b1; stateNext = ST_FALL; end
          else strb.nextCol = 1'b1;
        end
        ST_FALL:   begin strb.fallFclk   = 1'b1; stateNext = ST_RBEGIN; end
        ST_RBEGIN: begin strb.beginRight = 1'b1; stateNext = ST_RSCAN;  end
        ST_RSCAN:  begin
          if (lastCol) begin strb.endRight = 1'b1; stateNext = ST_RISE; end
          else strb.nextCol = 1'b1;
        end
        default:   stateNext = ST_RISE;
      endcase
    end
  end

  always_comb begin
    waitNext = waitCnt - WAIT_W'(1);
    if (strb.riseFclk || strb.fallFclk)
      waitNext = WAIT_W'(IDLE_LONG - 1);
    else if (strb.endLeft || strb.endRight)
      waitNext = WAIT_W'(IDLE_SHORT - 1);
    else if (strb.beginLeft || strb.beginRight)
      waitNext = WAIT_W'(COL_BASE - 1 + int'(COL_PATTERN[0]));
    else if (strb.nextCol)
      waitNext = WAIT_W'(COL_BASE - 1 + int'(nextBit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RISE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitNext;
    end
  end

endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int NUM_COLS = 384,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  sfsStrobes_t       strb,
  input  logic              bufSel,
  input  logic [7:0]        leftStart,
  input  logic [7:0]        rightStart,
  output logic              lastCol,
  output logic              nextBit,
  output logic              frameClk,
  output logic [1:0]        busyL,
  output logic [1:0]        busyR,
  output logic              colStrobe,
  output logic [COL_W-1:0]  colIdx,
  output logic [ADDR_W-1:0] tblAddr,
  output logic              evFrameStart,
  output logic              evLeftEnd,
  output logic              evRightEnd
);

  logic [3:0]  phase, phaseNext;
  logic [11:0] patBits;

  assign lastCol   = (colIdx == COL_W'(NUM_COLS - 1));
  assign phaseNext = (phase == 4'd11) ? 4'd0 : phase + 4'd1;
  assign patBits   = COL_PATTERN >> phaseNext;
  assign nextBit   = patBits[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      frameClk     <= 1'b0;
      busyL        <= '0;
      busyR        <= '0;
      colStrobe    <= 1'b0;
      colIdx       <= '0;
      phase        <= '0;
      tblAddr      <= '0;
      evFrameStart <= 1'b0;
      evLeftEnd    <= 1'b0;
      evRightEnd   <= 1'b0;
    end else begin
      colStrobe    <= strb.beginLeft | strb.beginRight | strb.nextCol;
      evFrameStart <= strb.riseFclk;
      evLeftEnd    <= strb.endLeft;
      evRightEnd   <= strb.endRight;
      if (strb.riseFclk) frameClk <= 1'b1;
      if (strb.fallFclk) frameClk <= 1'b0;
      if (strb.beginLeft) begin
        busyL[bufSel] <= 1'b1;
        colIdx        <= '0;
        phase         <= '0;
        tblAddr       <= LEFT_BASE | ADDR_W'({leftStart, 1'b0});
      end
      if (strb.beginRight) begin
        busyR[bufSel] <= 1'b1;
        colIdx        <= '0;
        phase         <= '0;
        tblAddr       <= RIGHT_BASE | ADDR_W'({rightStart, 1'b0});
      end
      if (strb.nextCol) begin
        colIdx <= colIdx + COL_W'(1);
        phase  <= phaseNext;
        if ((|busyL) && (colIdx[1:0] == 2'd3))
          tblAddr <= tblAddr - ADDR_W'(2);
      end
      if (strb.endLeft)  busyL <= '0;
      if (strb.endRight) busyR <= '0;
    end
  end

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $countones({busyL, busyR}) <= 1);  // R9
  AST_LEFT_IN_FCLK: assert property (@(posedge clk) disable iff (rst)
    (|busyL) |-> frameClk);  // R9
  AST_RIGHT_OUT_FCLK: assert property (@(posedge clk) disable iff (rst)
    (|busyR) |-> !frameClk);  // R9
  AST_STROBE_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
    colStrobe |-> (|{busyL, busyR}));  // R3
  AST_TBL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !colStrobe |-> $stable(tblAddr));  // R6
  AST_RIGHT_TBL_FIXED: assert property (@(posedge clk) disable iff (rst)
    (colStrobe && (|busyR) && colIdx != '0) |-> $stable(tblAddr));  // R7
  AST_FS_PULSE: assert property (@(posedge clk) disable iff (rst)
    evFrameStart |=> !evFrameStart);  // R2
  AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
    (evLeftEnd || evRightEnd) |=> !(evLeftEnd || evRightEnd));  // R4

endmodule

// File: rtl/stereo_frame_seq.sv
module stereo_frame_seq
  import sfs_pkg::*;
#(
  parameter int CLKS_PER_MS = 20000,
  parameter int NUM_COLS    = 384,
  parameter int COL_BASE    = 260,
  localparam int COL_W      = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bufSel,
  input  logic [7:0]        leftStart,
  input  logic [7:0]        rightStart,
  output logic              frameClk,
  output logic              busyLeft0,
  output logic              busyLeft1,
  output logic              busyRight0,
  output logic              busyRight1,
  output logic              colStrobe,
  output logic [COL_W-1:0]  colIdx,
  output logic [ADDR_W-1:0] tblAddr,
  output logic              evFrameStart,
  output logic              evLeftEnd,
  output logic              evRightEnd
);

  sfsStrobes_t strb;
  logic        lastCol, nextBit;
  logic [1:0]  busyL, busyR;

  sfs_ctrl #(.CLKS_PER_MS(CLKS_PER_MS), .COL_BASE(COL_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .lastCol(lastCol), .nextBit(nextBit), .strb(strb)
  );

  sfs_datapath #(.NUM_COLS(NUM_COLS)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .bufSel(bufSel),
    .leftStart(leftStart), .rightStart(rightStart),
    .lastCol(lastCol), .nextBit(nextBit), .frameClk(frameClk),
    .busyL(busyL), .busyR(busyR), .colStrobe(colStrobe), .colIdx(colIdx),
    .tblAddr(tblAddr), .evFrameStart(evFrameStart),
    .evLeftEnd(evLeftEnd), .evRightEnd(evRightEnd)
  );

  assign busyLeft0  = busyL[0];
  assign busyLeft1  = busyL[1];
  assign busyRight0 = busyR[0];
  assign busyRight1 = busyR[1];

endmodule

// File: tb/stereo_frame_seq_tb.sv
module stereo_frame_seq_tb;

  localparam int M = 20;
  localparam int N = 24;
  localparam int BASE = 260;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bufSel = 1'b0;
  logic [7:0] leftStart = 8'h00;
  logic [7:0] rightStart = 8'h00;
  logic frameClk, busyLeft0, busyLeft1, busyRight0, busyRight1, colStrobe;
  logic [$clog2(N)-1:0] colIdx;
  logic [17:0] tblAddr;
  logic evFrameStart, evLeftEnd, evRightEnd;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;
  longint prevRightEnd = -1;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  stereo_frame_seq #(.CLKS_PER_MS(M), .NUM_COLS(N), .COL_BASE(BASE)) u_dut (
    .clk(clk), .rst(rst), .bufSel(bufSel), .leftStart(leftStart),
    .rightStart(rightStart), .frameClk(frameClk), .busyLeft0(busyLeft0),
    .busyLeft1(busyLeft1), .busyRight0(busyRight0), .busyRight1(busyRight1),
    .colStrobe(colStrobe), .colIdx(colIdx), .tblAddr(tblAddr),
    .evFrameStart(evFrameStart), .evLeftEnd(evLeftEnd), .evRightEnd(evRightEnd)
  );

  function automatic int colPeriod(input int k);
    return BASE + ((12'hA94 >> (k % 12)) & 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // R1: outputs quiet while in reset
  task automatic t_reset();
    logic [7:0] outs;
    rst = 1'b1;
    bufSel = 1'b1; leftStart = 8'h55; rightStart = 8'hAA;
    repeat (5) @(negedge clk);
    outs = {frameClk, busyLeft0, busyLeft1, busyRight0, busyRight1,
            colStrobe, evFrameStart, evLeftEnd | evRightEnd};
    chk(outs == 8'h00, "R1", "outputs in reset", outs, 0);
    rst = 1'b0;
  endtask

  // One full frame, checking every event time, column and flag
  task automatic t_frame(input bit sel, input logic [7:0] lb, input logic [7:0] rb,
                         input bit flip, input bit first);
    longint tFs = -1, tLE = -1, tFall = -1, tRE = -1, expT = 0;
    int nFs = 0, nLE = 0, nRE = 0, kL = 0, kR = 0;
    bit prevF = 1'b0, rSel;
    logic [17:0] lStart, rStart;
    lStart = 18'h3DC00 | 18'({lb, 1'b0});
    rStart = 18'h3DE00 | 18'({rb, 1'b0});
    rSel = flip ? ~sel : sel;
    bufSel = sel; leftStart = lb; rightStart = rb;
    for (int i = 0; i < 20000 && tRE < 0; i++) begin
      @(negedge clk);
      if (evFrameStart) begin
        nFs++;
        if (tFs < 0) begin
          tFs = cyc;
          chk(frameClk == 1'b1, "R2", "frame clock at frame start", frameClk, 1);
          if (first) chk(tFs == 1, "R1", "first frame start cycle", tFs, 1);
          else chk(tFs == prevRightEnd + 2*M, "R5", "next frame start", tFs,
                   prevRightEnd + 2*M);
          expT = tFs + 3*M;
        end
      end
      if (prevF && !frameClk) tFall = cyc;
      prevF = frameClk;
      if (colStrobe && (busyLeft0 | busyLeft1) && tLE < 0) begin
        chk(cyc == expT, (kL == 0) ? "R2" : "R3", "left column start", cyc, expT);
        chk(colIdx == kL, "R3", "left column index", colIdx, kL);
        chk(tblAddr == lStart - 18'(2*(kL/4)), "R6", "left table address",
            tblAddr, lStart - 18'(2*(kL/4)));
        chk({busyLeft1, busyLeft0, busyRight1, busyRight0, frameClk} ==
            {sel, ~sel, 2'b00, 1'b1}, "R8", "left flags",
            {busyLeft1, busyLeft0, busyRight1, busyRight0, frameClk},
            {sel, ~sel, 2'b00, 1'b1});
        expT = expT + colPeriod(kL);
        kL++;
        if (flip && kL == 6) bufSel = ~sel;
      end
      if (evLeftEnd) begin
        nLE++;
        if (tLE < 0) begin
          tLE = cyc;
          chk(cyc == expT, "R4", "left end time", cyc, expT);
          chk({busyLeft0, busyLeft1} == 2'b00, "R4", "left busy cleared",
              {busyLeft0, busyLeft1}, 0);
        end
      end
      if (colStrobe && (busyRight0 | busyRight1)) begin
        if (kR == 0) begin
          chk(tFall == tLE + 2*M, "R4", "frame clock fall", tFall, tLE + 2*M);
          expT = tFall + 3*M;
        end
        chk(cyc == expT, (kR == 0) ? "R5" : "R3", "right column start", cyc, expT);
        chk(colIdx == kR, "R3", "right column index", colIdx, kR);
        chk(tblAddr == rStart, "R7", "right table address", tblAddr, rStart);
        chk({busyRight1, busyRight0, busyLeft1, busyLeft0, frameClk} ==
            {rSel, ~rSel, 2'b00, 1'b0}, "R8", "right flags",
            {busyRight1, busyRight0, busyLeft1, busyLeft0, frameClk},
            {rSel, ~rSel, 2'b00, 1'b0});
        expT = expT + colPeriod(kR);
        kR++;
      end
      if (evRightEnd) begin
        nRE++;
        tRE = cyc;
        chk(cyc == expT, "R5", "right end time", cyc, expT);
        chk({busyRight0, busyRight1} == 2'b00, "R5", "right busy cleared",
            {busyRight0, busyRight1}, 0);
      end
    end
    @(negedge clk);
    chk(!evRightEnd && !colStrobe, "R5", "right end pulse width", evRightEnd, 0);
    chk(nFs == 1, "R2", "frame start pulse cycles", nFs, 1);
    chk(nLE == 1, "R4", "left end pulse cycles", nLE, 1);
    chk(nRE == 1, "R5", "right end pulses", nRE, 1);
    chk(kL == N, "R3", "left column strobes", kL, N);
    chk(kR == N, "R3", "right column strobes", kR, N);
    prevRightEnd = tRE;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_frame(1'b0, 8'hFA, 8'hFA, 1'b0, 1'b1);
    t_frame(1'b1, 8'h00, 8'hFF, 1'b1, 1'b0);
    t_frame(1'b1, 8'h80, 8'h01, 1'b0, 1'b0);
    summary();
  end

endmodule